// File: doc/BRIEF.md
# Status Register and Privilege Tracker

This block keeps the processor's system Status register and works out, every cycle, whether the core is in effective user mode. User mode is not a stored flag. It is computed from the stored user bit, and the exception level, the error level and the debug-mode flag all hold it off. Software writes to Status go through a fixed implementation mask. Reads return the stored word as it is.

The block also executes the two return instructions. ERET resumes from the error return address or the exception return address and clears the matching level bit. DERET resumes from the debug return address and leaves debug mode. Both produce a one-cycle redirect pulse and a pulse that drops any load-linked reservation.

Two checks run combinationally against the current state. The first faults a system-coprocessor instruction issued from user mode while coprocessor 0 is not enabled. The second flags an address error for any user-mode address above the user segment.

Top module: `cp0_mode_unit`

## Requirements
- R1: Reset sets Status to exactly 0x00400004 (BEV at bit 22 and ERL at bit 2) and PC to 0xBFC00000. Reset also clears debug mode, user mode, the redirect pulse and the reservation-clear pulse.
- R2: A write that is not blocked stores the written word ANDed with 0xF878FF17, and the read port shows it from the next cycle. The read port returns the stored word unaltered.
- R3: User mode is 1 exactly when Status bit 4 (UM) is 1, bit 1 (EXL) is 0, bit 2 (ERL) is 0 and debug mode is off. It follows the current state with no added delay.
- R4: ERET while ERL is 1 loads PC from the error return address and clears ERL only. EXL and every other bit stay as they were.
- R5: ERET while ERL is 0 loads PC from the exception return address and clears EXL.
- R6: A DERET that is taken loads PC from the debug return address and clears debug mode. Status does not change.
- R7: One cycle after a taken ERET or DERET, the redirect and reservation-clear outputs are 1 for exactly one cycle. User mode is then recomputed from the updated bits.
- R8: The debug-entry strobe sets debug mode unless a DERET is taken in the same cycle. While debug mode is on, user mode is 0.
- R9: ERET takes priority over DERET, and a DERET that arrives together with an ERET is ignored. A Status write in the same cycle as either return is dropped.
- R10: The coprocessor-unusable output is 1 exactly when a system-coprocessor instruction strobe occurs in user mode with Status bit 28 (CU0) at 0.
- R11: The address-error output is 1 exactly when user mode is on and the address is above 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Status write enable |
| wr_data_i | input | 32 | Status write data |
| rd_data_o | output | 32 | Stored Status word |
| eret_i | input | 1 | Exception-return strobe |
| deret_i | input | 1 | Debug-return strobe |
| epc_i | input | 32 | Exception return address |
| errorepc_i | input | 32 | Error return address |
| depc_i | input | 32 | Debug return address |
| dbg_enter_i | input | 1 | Debug-mode entry strobe |
| pc_o | output | 32 | Program counter after reset or a return |
| redirect_o | output | 1 | One-cycle pulse: PC was just reloaded |
| ll_clear_o | output | 1 | One-cycle pulse: drop load-linked reservation |
| dbg_mode_o | output | 1 | Debug mode flag |
| user_mode_o | output | 1 | Effective user mode |
| cp0_op_i | input | 1 | System-coprocessor instruction strobe |
| cop_unusable_o | output | 1 | Coprocessor 0 unusable fault |
| addr_i | input | 32 | Address to check |
| addr_err_o | output | 1 | User address out of range |

## Verification
The hardest state to reach from the ports is effective user mode. Reset leaves ERL set, so user mode needs a Status write with UM set and both level bits clear, with no debug entry pending. The fault and address-error checks only mean something once the block is there. The stimulus therefore shapes half of its random write data to set UM and clear EXL and ERL. Directed steps write all ones and then peel off ERL and EXL with two ERETs, so the block steps through both return paths before it reaches user mode.

// File: rtl/cp0_mode_pkg.sv
package cp0_mode_pkg;
  localparam int unsigned STAT_W  = 32;
  localparam int unsigned BIT_IE  = 0;
  localparam int unsigned BIT_EXL = 1;
  localparam int unsigned BIT_ERL = 2;
  localparam int unsigned BIT_UM  = 4;
  localparam int unsigned BIT_BEV = 22;
  localparam int unsigned BIT_CU0 = 28;

  typedef logic [STAT_W-1:0] stat_t;

  localparam stat_t STAT_WMASK = 32'hF878_FF17;
  localparam stat_t STAT_RESET = stat_t'(1) << BIT_BEV | stat_t'(1) << BIT_ERL;

  // effective user mode from the stored bits and the debug flag
  function automatic logic user_mode_f(stat_t st, logic dbg);
    return st[BIT_UM] & ~st[BIT_EXL] & ~st[BIT_ERL] & ~dbg;
  endfunction

  // Status after ERET: the error level is dropped first, else the exception level
  function automatic stat_t eret_status_f(stat_t st);
    stat_t r;
    r = st;
    if (st[BIT_ERL]) r[BIT_ERL] = 1'b0;
    else             r[BIT_EXL] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/cp0_stat_reg.sv
module cp0_stat_reg
  import cp0_mode_pkg::*;
#(
  parameter stat_t WMASK   = STAT_WMASK,
  parameter stat_t RST_VAL = STAT_RESET
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  stat_t wr_data,
  input  logic  eret,
  input  logic  deret,
  output stat_t status_q
);
  logic  wr_take;
  logic  ret_any;
  stat_t status_d;

  assign ret_any = eret | deret;
  assign wr_take = wr_en & ~ret_any;

  always_comb begin
    status_d = status_q;
    if (eret)         status_d = eret_status_f(status_q);
    else if (wr_take) status_d = wr_data & WMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= RST_VAL;
    else        status_q <= status_d;
  end

  localparam stat_t LEVEL_BITS = stat_t'(1) << BIT_EXL | stat_t'(1) << BIT_ERL;

  a_r2_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> status_q == ($past(wr_data) & WMASK));
  a_r9_return_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    ret_any |=> ((status_q ^ $past(status_q)) & ~LEVEL_BITS) == '0);
  a_r4_erl_first: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && status_q[BIT_ERL]) |=> !status_q[BIT_ERL] && status_q[BIT_EXL] == $past(status_q[BIT_EXL]));
  a_r5_exl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !status_q[BIT_ERL]) |=> !status_q[BIT_EXL]);
endmodule

// File: rtl/cp0_ret_ctl.sv
module cp0_ret_ctl #(
  parameter int unsigned PC_W = 32,
  parameter logic [PC_W-1:0] RST_PC = 32'hBFC0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eret,
  input  logic            deret,
  input  logic            erl_now,
  input  logic            dbg_enter,
  input  logic [PC_W-1:0] epc,
  input  logic [PC_W-1:0] errorepc,
  input  logic [PC_W-1:0] depc,
  output logic [PC_W-1:0] pc_q,
  output logic            redirect_q,
  output logic            ll_clear_q,
  output logic            dbg_q
);
  logic            deret_take;
  logic            ret_any;
  logic [PC_W-1:0] pc_d;
  logic            dbg_d;

  assign deret_take = deret & ~eret;
  assign ret_any    = eret | deret;

  always_comb begin
    pc_d = pc_q;
    if (eret)            pc_d = erl_now ? errorepc : epc;
    else if (deret_take) pc_d = depc;
  end

  always_comb begin
    dbg_d = dbg_q;
    if (deret_take)     dbg_d = 1'b0;
    else if (dbg_enter) dbg_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q       <= RST_PC;
      dbg_q      <= 1'b0;
      redirect_q <= 1'b0;
      ll_clear_q <= 1'b0;
    end else begin
      pc_q       <= pc_d;
      dbg_q      <= dbg_d;
      redirect_q <= ret_any;
      ll_clear_q <= ret_any;
    end
  end

  a_r4_pc_from_errorepc: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && erl_now) |=> pc_q == $past(errorepc));
  a_r5_pc_from_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !erl_now) |=> pc_q == $past(epc));
  a_r6_deret_leaves_debug: assert property (@(posedge clk) disable iff (!rst_n)
    deret_take |=> !dbg_q && pc_q == $past(depc));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_q && !$past(ret_any)) |-> 1'b0);
  a_r8_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_enter && !deret_take) |=> dbg_q);
endmodule

// File: rtl/cp0_priv_chk.sv
module cp0_priv_chk
  import cp0_mode_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] USER_TOP = 32'h7FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stat_t             status,
  input  logic              dbg,
  input  logic              cp0_op,
  input  logic [ADDR_W-1:0] addr,
  output logic              user_mode,
  output logic              cop_unusable,
  output logic              addr_err
);
  function automatic logic beyond_user_f(logic [ADDR_W-1:0] a);
    return a > USER_TOP;
  endfunction

  assign user_mode    = user_mode_f(status, dbg);
  assign cop_unusable = cp0_op & user_mode & ~status[BIT_CU0];
  assign addr_err     = user_mode & beyond_user_f(addr);

  a_r3_user_gated: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> !dbg && !status[BIT_EXL] && !status[BIT_ERL] && status[BIT_UM]);
  a_r10_fault_only_user: assert property (@(posedge clk) disable iff (!rst_n)
    cop_unusable |-> user_mode && cp0_op && !status[BIT_CU0]);
  a_r11_addr_only_user: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> user_mode && addr[ADDR_W-1]);
endmodule

// File: rtl/cp0_mode_unit.sv
module cp0_mode_unit
  import cp0_mode_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PC_W   = 32,
  parameter logic [PC_W-1:0] RST_PC = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] USER_TOP = 32'h7FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic              eret_i,
  input  logic              deret_i,
  input  logic [PC_W-1:0]   epc_i,
  input  logic [PC_W-1:0]   errorepc_i,
  input  logic [PC_W-1:0]   depc_i,
  input  logic              dbg_enter_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              redirect_o,
  output logic              ll_clear_o,
  output logic              dbg_mode_o,
  output logic              user_mode_o,
  input  logic              cp0_op_i,
  output logic              cop_unusable_o,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              addr_err_o
);
  stat_t status_q;
  logic  dbg_q;

  cp0_stat_reg #(.WMASK(STAT_WMASK), .RST_VAL(STAT_RESET)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .eret(eret_i), .deret(deret_i), .status_q(status_q)
  );

  cp0_ret_ctl #(.PC_W(PC_W), .RST_PC(RST_PC)) u_ret (
    .clk(clk), .rst_n(rst_n), .eret(eret_i), .deret(deret_i),
    .erl_now(status_q[BIT_ERL]), .dbg_enter(dbg_enter_i),
    .epc(epc_i), .errorepc(errorepc_i), .depc(depc_i),
    .pc_q(pc_o), .redirect_q(redirect_o), .ll_clear_q(ll_clear_o), .dbg_q(dbg_q)
  );

  cp0_priv_chk #(.ADDR_W(ADDR_W), .USER_TOP(USER_TOP)) u_chk (
    .clk(clk), .rst_n(rst_n), .status(status_q), .dbg(dbg_q), .cp0_op(cp0_op_i),
    .addr(addr_i), .user_mode(user_mode_o), .cop_unusable(cop_unusable_o),
    .addr_err(addr_err_o)
  );

  assign rd_data_o  = status_q;
  assign dbg_mode_o = dbg_q;
endmodule

// File: tb/cp0_mode_unit_bench.sv
module cp0_mode_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0, eret_i = 1'b0, deret_i = 1'b0, dbg_enter_i = 1'b0, cp0_op_i = 1'b0;
  logic [31:0] wr_data_i = '0, epc_i = '0, errorepc_i = '0, depc_i = '0, addr_i = '0;
  logic [31:0] rd_data_o, pc_o;
  logic        redirect_o, ll_clear_o, dbg_mode_o, user_mode_o, cop_unusable_o, addr_err_o;

  int errors = 0;
  int checks = 0;

  // bench model state
  logic [31:0] m_stat, m_pc;
  logic        m_dbg, m_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp0_mode_unit u_cp0_mode_unit (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .eret_i(eret_i), .deret_i(deret_i), .epc_i(epc_i), .errorepc_i(errorepc_i), .depc_i(depc_i),
    .dbg_enter_i(dbg_enter_i), .pc_o(pc_o), .redirect_o(redirect_o), .ll_clear_o(ll_clear_o),
    .dbg_mode_o(dbg_mode_o), .user_mode_o(user_mode_o), .cp0_op_i(cp0_op_i),
    .cop_unusable_o(cop_unusable_o), .addr_i(addr_i), .addr_err_o(addr_err_o)
  );

  function automatic logic exp_user(logic [31:0] st, logic dbg);
    // R3: bit 4 set, bits 1 and 2 clear, not in debug
    return (st & 32'h16) == 32'h10 && !dbg;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    chk("R2 read", rd_data_o, m_stat);
    chk("R4/R5/R6 pc", pc_o, m_pc);
    chk("R6/R8 debug", {31'd0, dbg_mode_o}, {31'd0, m_dbg});
    chk("R7 redirect", {31'd0, redirect_o}, {31'd0, m_pulse});
    chk("R7 ll_clear", {31'd0, ll_clear_o}, {31'd0, m_pulse});
    chk("R3 user", {31'd0, user_mode_o}, {31'd0, exp_user(m_stat, m_dbg)});
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(logic wr, logic [31:0] wd, logic er, logic de, logic den,
                      logic cp, logic [31:0] ad);
    logic u;
    check_regs();
    wr_en_i = wr; wr_data_i = wd; eret_i = er; deret_i = de; dbg_enter_i = den;
    cp0_op_i = cp; addr_i = ad;
    epc_i = $urandom; errorepc_i = $urandom; depc_i = $urandom;
    #1;
    u = exp_user(m_stat, m_dbg);
    chk("R10 cop_unusable", {31'd0, cop_unusable_o}, {31'd0, cp & u & ~m_stat[28]});
    chk("R11 addr_err", {31'd0, addr_err_o}, {31'd0, u & (ad > 32'h7FFF_FFFF)});
    @(posedge clk);
    m_pulse = er | de;
    if (er) begin
      if (m_stat[2]) begin m_pc = errorepc_i; m_stat[2] = 1'b0; end
      else begin m_pc = epc_i; m_stat[1] = 1'b0; end
      if (den) m_dbg = 1'b1;
    end else if (de) begin
      m_pc = depc_i; m_dbg = 1'b0;
    end else begin
      if (wr) m_stat = wd & 32'hF878_FF17;
      if (den) m_dbg = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_stat = 32'h0040_0004; m_pc = 32'hBFC0_0000; m_dbg = 1'b0; m_pulse = 1'b0;
    // R1 reset state
    chk("R1 status", rd_data_o, 32'h0040_0004);
    chk("R1 pc", pc_o, 32'hBFC0_0000);
    chk("R1 flags", {28'd0, dbg_mode_o, user_mode_o, redirect_o, ll_clear_o}, 32'd0);

    // R2 mask, then R4, R5, R7 peel the levels off to reach user mode
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    chk("R2 mask", rd_data_o, 32'hF878_FF17);
    step(0, 0, 1, 0, 0, 0, 0);                 // R4 ERL first
    step(0, 0, 1, 0, 0, 1, 32'h8000_0000);     // R5 EXL next
    chk("R7 user after eret", {31'd0, user_mode_o}, 32'd1);
    step(0, 0, 0, 0, 0, 1, 32'h8000_0000);     // CU0 set: no fault, R11 error
    step(1, 32'h0000_0010, 0, 0, 0, 1, 32'h7FFF_FFFF); // R10 boundary address
    step(0, 0, 0, 0, 0, 1, 32'h8000_0000);     // R10 fault with CU0 clear
    step(0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF);     // R8 enter debug
    step(0, 0, 0, 1, 1, 1, 32'hFFFF_FFFF);     // R6 DERET beats entry
    step(1, 32'h0000_0006, 1, 1, 0, 0, 0);     // R9 both returns plus write
    step(1, 32'h0000_0006, 0, 1, 0, 0, 0);     // R9 DERET drops write

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd;
      wd = $urandom;
      if ($urandom_range(1, 0) == 1) wd = (wd & ~32'h6) | 32'h10;
      step($urandom_range(2, 0) == 0, wd, $urandom_range(9, 0) == 0,
           $urandom_range(11, 0) == 0, $urandom_range(15, 0) == 0,
           $urandom_range(1, 0) == 1, $urandom);
    end
    check_regs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule